// File: doc/BRIEF.md
# Serial-bus byte memory command controller

This block is the slave side of a four-wire serial bus (clock, active-low select, data in, data out) in front of a byte-wide nonvolatile store of 2048 locations. The host lowers select, shifts in a one-byte opcode and then address and data bytes, most significant bit first, and raises select to end the transaction. The opcodes handled are: set and clear a write-permission latch, read and write a status byte, and read and write the store. The store itself is a plain register array inside the block.

All bus pins are synchronised into the system clock domain, and bus clock edges are found there. The bus clock may therefore stop and restart at any moment. Writes are committed when select rises. An internal write takes a parameterised number of system clocks. During that time a busy flag reads 1. When the busy time ends, the busy flag and the write-permission latch both clear. The bus has no flow control: data moves one bit per bus clock edge, and the host paces transfers by holding the clock. A host that must not collide with a write polls the busy flag.

Top module: `spimem_ctrl`

## Requirements
- R1: After reset, so is 0 and the status byte reads 0x00. so stays 0 whenever select is high.
- R2: Opcode 0x06 sets the write-permission latch (status bit 1) and opcode 0x04 clears it. Each takes effect once its eighth bit is shifted in.
- R3: A store write (opcode 0x02) issued while the latch is clear is discarded. The addressed byte keeps its old value.
- R4: A store write with the latch set commits, when select rises, the last complete data byte received. It goes to the address taken from the low 11 bits of the two address bytes; the upper 5 bits are ignored.
- R5: Once a write commits, the busy flag (status bit 0) reads 1 for BUSY_CYCLES system clocks and the status byte stays readable. When the busy period ends, the busy flag and the latch both clear.
- R6: While busy, a store write or status write is discarded, and opcodes 0x06 and 0x04 have no effect.
- R7: Opcode 0x03 followed by two address bytes returns bytes from consecutive addresses for as long as clocks continue. The address wraps from 0x7FF to 0x000.
- R8: Opcode 0x01 followed by a data byte writes status bits 7..2 when select rises. Bits 1 and 0 cannot be written. The commit follows the same permission and busy rules as a store write.
- R9: An opcode other than those listed is ignored until select rises: so stays 0 and no state changes.
- R10: Bits travel most significant bit first. so changes only after a falling bus clock edge, and a bus clock paused mid-byte resumes without losing bits.
- R11: Opcode 0x05 returns the current status byte, and repeats it for every further byte clocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Bus clock from the host, idles low |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |

## Verification
The bench keeps the default 11-bit address and sets BUSY_CYCLES to 1200. With that value, a write rejected because of the busy flag, an ignored latch-clear opcode and a status read all fit inside one busy window at a bus half-period of eight system clocks. The same value still lets the bench wait out the busy period cheaply. The full address width is kept so that the wrap from the top address to zero, and the dropping of the upper address bits, are exercised on the real boundary.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DIN,
    PH_DOUT,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_SETWP  = 8'h06;
  localparam logic [7:0] OP_CLRWP  = 8'h04;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[i]}};
      else        st <= {st[0], d[i]};
    end
    assign q[i] = st[1];
  end
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so
);
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int ABW        = $clog2(ADDR_BYTES + 1);
  localparam int BW         = $clog2(BUSY_CYCLES + 1);
  localparam int LOW_W      = ADDR_W - 8;

  logic [2:0] s_pins;
  logic s_cs_n, s_sck, s_si, sck_q, cs_q;
  logic sck_rise, sck_fall, cs_end;

  spimem_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(s_pins)
  );
  assign {s_cs_n, s_sck, s_si} = s_pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= s_sck;
      cs_q  <= s_cs_n;
    end
  end

  assign sck_rise = s_sck & ~sck_q & ~s_cs_n;
  assign sck_fall = ~s_sck & sck_q & ~s_cs_n;
  assign cs_end   = s_cs_n & ~cs_q;

  phase_t           phase;
  logic [2:0]       bit_cnt;
  logic [6:0]       sh;
  logic [7:0]       byte_in, op, wdata, tx, rd_data;
  logic [ABW-1:0]   abyte;
  logic [LOW_W-1:0] addr_lo;
  logic [ADDR_W-1:0] addr_nx, ptr, rd_idx;
  logic             wr_ok, have_data, wel, wip, commit, mem_we, sr_we;
  logic [5:0]       st_hi;
  logic [BW-1:0]    busy_cnt;
  logic [7:0]       status;

  assign byte_in = {sh, s_si};
  assign addr_nx = {addr_lo, byte_in};
  assign rd_idx  = (phase == PH_ADDR) ? addr_nx : ptr;
  assign status  = {st_hi, wel, wip};
  assign wip     = (busy_cnt != '0);
  assign commit  = cs_end && wr_ok && have_data && wel && !wip;
  assign mem_we  = commit && (op == OP_WRITE);
  assign sr_we   = commit && (op == OP_WRSTAT);

  spimem_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(wdata),
    .raddr(rd_idx), .rdata(rd_data)
  );

  // busy timer: loaded on commit, counts down to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (commit)   busy_cnt <= BW'(BUSY_CYCLES);
    else if (wip)      busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; bit_cnt <= '0; sh <= '0; op <= '0;
      addr_lo <= '0; ptr <= '0; tx <= '0; so <= 1'b0;
      wr_ok <= 1'b0; have_data <= 1'b0; wdata <= '0;
      abyte <= '0; wel <= 1'b0; st_hi <= '0;
    end else begin
      if (busy_cnt == BW'(1)) wel <= 1'b0;
      if (sr_we) st_hi <= wdata[7:2];
      if (s_cs_n) begin
        phase <= PH_CMD; bit_cnt <= '0; so <= 1'b0;
        have_data <= 1'b0; wr_ok <= 1'b0; abyte <= '0;
      end else begin
        if (sck_fall && phase == PH_DOUT) begin
          so <= tx[7];
          tx <= {tx[6:0], 1'b0};
        end
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= byte_in[6:0];
          if (bit_cnt == 3'd7) begin
            unique case (phase)
              PH_CMD: begin
                op    <= byte_in;
                wr_ok <= wel && !wip;
                phase <= PH_SKIP;
                unique case (byte_in)
                  OP_SETWP:  if (!wip) wel <= 1'b1;
                  OP_CLRWP:  if (!wip) wel <= 1'b0;
                  OP_RDSTAT: begin tx <= status; phase <= PH_DOUT; end
                  OP_WRSTAT: phase <= PH_DIN;
                  OP_READ, OP_WRITE: phase <= PH_ADDR;
                  default: ;
                endcase
              end
              PH_ADDR: begin
                addr_lo <= addr_nx[LOW_W-1:0];
                abyte   <= abyte + 1'b1;
                if (abyte == ABW'(ADDR_BYTES - 1)) begin
                  if (op == OP_READ) begin
                    tx    <= rd_data;
                    ptr   <= addr_nx + 1'b1;
                    phase <= PH_DOUT;
                  end else begin
                    ptr   <= addr_nx;
                    phase <= PH_DIN;
                  end
                end
              end
              PH_DIN: begin
                wdata     <= byte_in;
                have_data <= 1'b1;
              end
              PH_DOUT: begin
                if (op == OP_RDSTAT) tx <= status;
                else begin
                  tx  <= rd_data;
                  ptr <= ptr + 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/spimem_ctrl_chk.sv
module spimem_ctrl_chk
  import spimem_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wip,
  input logic       wel,
  input logic       mem_we,
  input logic       sr_we,
  input logic       so,
  input logic       s_cs_n,
  input logic       sck_fall,
  input logic       sck_rise,
  input logic [2:0] bit_cnt,
  input phase_t     phase,
  input logic [7:0] byte_in
);
  a_r5_wel_drops_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  a_r4_commit_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || sr_we) |=> wip);

  a_r6_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || sr_we) |-> !wip);

  a_r1_so_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs_n && $past(s_cs_n)) |-> !so);

  a_r10_so_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> ($past(sck_fall) || $past(s_cs_n)));

  a_r2_latch_set_by_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(sck_rise && bit_cnt == 3'd7 && phase == PH_CMD
                         && byte_in == OP_SETWP));
endmodule

bind spimem_ctrl spimem_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wip(wip), .wel(wel), .mem_we(mem_we),
  .sr_we(sr_we), .so(so), .s_cs_n(s_cs_n), .sck_fall(sck_fall),
  .sck_rise(sck_rise), .bit_cnt(bit_cnt), .phase(phase), .byte_in(byte_in)
);

// File: tb/spimem_ctrl_tb.sv
module spimem_ctrl_tb;
  localparam int BUSY = 1200;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  always #5 clk = ~clk;

  spimem_ctrl #(.ADDR_W(11), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run one transaction of n bytes; pause holds sck mid-byte in byte 1
  task automatic xact(input int n, input bit pause);
    cs_n = 1'b0;
    clks(H);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        si = txb[k][b];
        clks(H);
        rxb[k][b] = so;
        if (pause && k == 1 && b == 4) clks(60);
        sck = 1'b1;
        clks(H);
        sck = 1'b0;
      end
    end
    clks(H);
    cs_n = 1'b1;
    clks(12);
  endtask

  task automatic op1(input logic [7:0] o);
    txb[0] = o;
    xact(1, 1'b0);
  endtask

  task automatic rdstat(output logic [7:0] s);
    txb[0] = 8'h05; txb[1] = 8'h00;
    xact(2, 1'b0);
    s = rxb[1];
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    txb[0] = 8'h02; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = d;
    xact(4, 1'b0);
  endtask

  task automatic rd1(input logic [15:0] a, output logic [7:0] d);
    txb[0] = 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = 8'h00;
    xact(4, 1'b0);
    d = rxb[3];
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk(so === 1'b0, "R1 so after reset", so, 0);
    rdstat(s);
    chk(s === 8'h00, "R1 status after reset", s, 8'h00);
    chk(so === 1'b0, "R1 so deselected", so, 0);
  endtask

  task automatic t_latch;
    logic [7:0] s;
    op1(8'h06); rdstat(s);
    chk(s === 8'h02, "R2 set latch", s, 8'h02);
    op1(8'h04); rdstat(s);
    chk(s === 8'h00, "R2 clear latch", s, 8'h00);
  endtask

  task automatic t_write_busy;
    logic [7:0] s, d;
    op1(8'h06);
    txb[0] = 8'h02; txb[1] = 8'hF8; txb[2] = 8'h10; txb[3] = 8'h33; txb[4] = 8'hC4;
    xact(5, 1'b0);
    op1(8'h04);          // ignored while busy (R6)
    wr(16'h0010, 8'h77); // discarded while busy (R6)
    rdstat(s);
    chk(s === 8'h03, "R5 busy status readable", s, 8'h03);
    chk(s[1] === 1'b1, "R6 latch-clear ignored while busy", s[1], 1);
    clks(BUSY);
    rdstat(s);
    chk(s === 8'h00, "R5 busy and latch clear after write", s, 8'h00);
    rd1(16'h0010, d);
    chk(d === 8'hC4, "R4 last byte committed, upper address ignored", d, 8'hC4);
    chk(d !== 8'h77, "R6 busy write discarded", d, 8'hC4);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    wr(16'h0010, 8'h99);
    rd1(16'h0010, d);
    chk(d === 8'hC4, "R3 write without latch discarded", d, 8'hC4);
  endtask

  task automatic t_status_write;
    logic [7:0] s;
    op1(8'h06);
    txb[0] = 8'h01; txb[1] = 8'hFF;
    xact(2, 1'b0);
    rdstat(s);
    chk(s === 8'hFF, "R8 status written, busy", s, 8'hFF);
    clks(BUSY);
    rdstat(s);
    chk(s === 8'hFC, "R8 low bits not writable", s, 8'hFC);
    txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    xact(4, 1'b0);
    chk(rxb[2] === 8'hFC && rxb[3] === 8'hFC, "R11 status repeats", rxb[3], 8'hFC);
    op1(8'h06);
    txb[0] = 8'h01; txb[1] = 8'h00;
    xact(2, 1'b0);
    clks(BUSY);
    rdstat(s);
    chk(s === 8'h00, "R8 status restored", s, 8'h00);
  endtask

  task automatic t_wrap;
    op1(8'h06); wr(16'h07FF, 8'hA5); clks(BUSY);
    op1(8'h06); wr(16'h0000, 8'h3C); clks(BUSY);
    op1(8'h06); wr(16'h0001, 8'h81); clks(BUSY);
    txb[0] = 8'h03; txb[1] = 8'h07; txb[2] = 8'hFF;
    txb[3] = 8'h00; txb[4] = 8'h00; txb[5] = 8'h00;
    xact(6, 1'b1);
    chk(rxb[3] === 8'hA5, "R7 top address", rxb[3], 8'hA5);
    chk(rxb[4] === 8'h3C, "R7 wrap to zero", rxb[4], 8'h3C);
    chk(rxb[5] === 8'h81, "R10 msb-first after paused clock", rxb[5], 8'h81);
  endtask

  task automatic t_badop;
    logic [7:0] s;
    op1(8'h06);
    txb[0] = 8'hAB; txb[1] = 8'h04; txb[2] = 8'h00;
    xact(3, 1'b0);
    chk(rxb[1] === 8'h00 && rxb[2] === 8'h00, "R9 so quiet on unknown opcode", rxb[2], 0);
    rdstat(s);
    chk(s === 8'h02, "R9 no state change", s, 8'h02);
    op1(8'h04);
  endtask

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(5);
    t_reset();
    t_latch();
    t_write_busy();
    t_locked();
    t_status_write();
    t_wrap();
    t_badop();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule